// File: doc/BRIEF.md
# Multiplexed VFD Grid Scan and Dimming Timer

This block produces the time base for a vacuum fluorescent display that is multiplexed over two or three grids. As the cascade master it divides the oscillator clock into bit times and walks through grid slots of 1024 bit times each. In each slot it pulls one active-low grid strobe low and gates the matching 56-bit segment latch onto the segment outputs for a number of bit times set by a 10-bit dimming value. The grid strobe opens three bit times before the segments light and closes together with them. The block also exports the segment-enable pulse and a 2-bit code naming the grid being scanned, so that a second copy can follow the master.

As a slave the block keeps its own timer off its outputs. It picks a latch from the incoming 2-bit code, gates that latch with the incoming dim pulse, holds every grid strobe inactive and holds its own dim and code outputs low. The serial loading of the latches and the analog output stages are outside this block.

Top module: `vfd_scan_dim`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, the segment outputs are all zero, the grid strobes are all high, and the dim and code outputs are low. The duty held after reset is zero, so the first slot after reset shows a 3-bit-time grid window and no segment pulse.
- R2: One bit time is 4 clock cycles, and one grid slot is 1024 bit times (4096 cycles). Grid strobes are active low.
- R3: In master mode with duty D, the active grid strobe is low for D+3 bit times from the start of the slot. `dim_out` is high for D bit times, starting 3 bit times after the strobe falls and ending in the same cycle as the strobe rises.
- R4: With duty 0 no segment pulse occurs, the grid window is 3 bit times, and the scan and code outputs still advance slot by slot.
- R5: A dimming value above 1016 is used as 1016.
- R6: `dim_val` is sampled once, at the start of each slot. A change made during a slot leaves that slot's widths unchanged and applies from the next slot.
- R7: With `duplex_sel` low (three grids) the slots run grid 1, 2, 3 and repeat. With `duplex_sel` high (two grids) they run grid 1, 2 and repeat, and grid 3 (`grid_n[2]`) never goes low. A switch to two grids made while grid 1 is being scanned continues with grid 2.
- R8: In master mode `sync_out` carries the code of the grid of the current slot for the whole of its strobe window: grid 1 gives `sync_out`=2'b01, grid 2 gives 2'b10, grid 3 gives 2'b11. Bit 0 is the first sync line.
- R9: In master mode the segments equal the current grid's latch (`lat1` for grid 1, `lat2` for grid 2, `lat3` for grid 3) while `dim_out` is high and are zero otherwise. `dim_in` and `sync_in` have no effect.
- R10: In slave mode (`master_sel` low), one cycle after the inputs are applied, the segments equal the latch chosen by `sync_in` if `dim_in` is high and zero if it is low. The codes are the same as in R8, and 2'b00 selects no latch (all zero). All grid strobes are high, and `dim_out` and `sync_out` are low.
- R11: At most one grid strobe is low in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_sel | input | 1 | High: master (own timer); low: slave |
| duplex_sel | input | 1 | High: two grids; low: three grids |
| dim_val | input | 10 | Segment on-time per slot in bit times |
| lat1 | input | 56 | Segment latch for grid 1 |
| lat2 | input | 56 | Segment latch for grid 2 |
| lat3 | input | 56 | Segment latch for grid 3 |
| dim_in | input | 1 | Slave: segment gate from the master |
| sync_in | input | 2 | Slave: latch-select code from the master |
| seg_out | output | 56 | Segment drive, high lights a segment |
| grid_n | output | 3 | Active-low grid strobes |
| dim_out | output | 1 | Master: segment-enable pulse for a slave |
| sync_out | output | 2 | Master: code of the grid being scanned |

## Verification
The cycle that ends a slot does three things at once: it samples a new duty, advances the grid index, and reacts to any change of the grid count. The bench provokes this by changing `dim_val` or `duplex_sel` inside a slot, so that the change meets the next slot boundary. It then judges the slot in progress against the old widths and the next slot against the new duty and the expected grid. A second overlap is the pulse window meeting the latch selection: the master pulse is checked, sample by sample, against the latch of the grid that the code output names, while the bench feeds random values into the slave inputs, which must be ignored.

// File: rtl/vfd_scan_pkg.sv
package vfd_scan_pkg;

    // Latch-select code; bit 0 is the first sync line
    typedef logic [1:0] sel_code_t;

    localparam sel_code_t SEL_BLANK = 2'b00;
    localparam sel_code_t SEL_G1    = 2'b01;
    localparam sel_code_t SEL_G2    = 2'b10;
    localparam sel_code_t SEL_G3    = 2'b11;

    localparam int MAX_GRIDS = 3;

    // Grid index (0-based) to the code exported on the sync lines
    function automatic sel_code_t grid_code(input logic [1:0] idx);
        case (idx)
            2'd0:    return SEL_G1;
            2'd1:    return SEL_G2;
            2'd2:    return SEL_G3;
            default: return SEL_BLANK;
        endcase
    endfunction

endpackage

// File: rtl/vfd_bit_timer.sv
module vfd_bit_timer #(
    parameter int PRESCALE  = 4,
    parameter int SLOT_BITS = 1024,
    localparam int PRE_W    = (PRESCALE > 1) ? $clog2(PRESCALE) : 1,
    localparam int BIT_W    = $clog2(SLOT_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [BIT_W-1:0] bit_pos,
    output logic             slot_end
);

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [BIT_W-1:0] pos;
    } tmr_t;

    tmr_t t_d, t_q;
    logic bit_tick;
    logic last_bit;

    always_comb begin
        t_d      = t_q;
        bit_tick = (t_q.pre == PRE_W'(PRESCALE - 1));
        last_bit = (t_q.pos == BIT_W'(SLOT_BITS - 1));
        if (bit_tick) begin
            t_d.pre = '0;
            t_d.pos = last_bit ? '0 : t_q.pos + 1'b1;
        end else begin
            t_d.pre = t_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign bit_pos  = t_q.pos;
    assign slot_end = bit_tick && last_bit;

endmodule

// File: rtl/vfd_grid_seq.sv
module vfd_grid_seq (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       slot_end,
    input  logic       duplex_sel,
    output logic [1:0] grid_idx
);

    logic [1:0] idx_d, idx_q;
    logic [1:0] last_idx;

    always_comb begin
        idx_d    = idx_q;
        last_idx = duplex_sel ? 2'd1 : 2'd2;
        if (slot_end) begin
            idx_d = (idx_q >= last_idx) ? 2'd0 : idx_q + 2'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) idx_q <= 2'd0;
        else        idx_q <= idx_d;
    end

    assign grid_idx = idx_q;

endmodule

// File: rtl/vfd_duty_reg.sv
module vfd_duty_reg #(
    parameter int DIM_W    = 10,
    parameter int DUTY_MAX = 1016
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slot_end,
    input  logic [DIM_W-1:0] dim_val,
    output logic [DIM_W-1:0] duty
);

    logic [DIM_W-1:0] duty_d, duty_q;

    always_comb begin
        duty_d = duty_q;
        if (slot_end) begin
            duty_d = (dim_val > DIM_W'(DUTY_MAX)) ? DIM_W'(DUTY_MAX) : dim_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) duty_q <= '0;
        else        duty_q <= duty_d;
    end

    assign duty = duty_q;

endmodule

// File: rtl/vfd_seg_select.sv
module vfd_seg_select
    import vfd_scan_pkg::*;
#(
    parameter int SEG_W = 56
) (
    input  sel_code_t        code,
    input  logic             gate,
    input  logic [SEG_W-1:0] lat_a,
    input  logic [SEG_W-1:0] lat_b,
    input  logic [SEG_W-1:0] lat_c,
    output logic [SEG_W-1:0] seg
);

    logic [SEG_W-1:0]     bank [MAX_GRIDS];
    logic [MAX_GRIDS-1:0] hit;

    assign bank[0] = lat_a;
    assign bank[1] = lat_b;
    assign bank[2] = lat_c;

    for (genvar g = 0; g < MAX_GRIDS; g++) begin : g_hit
        assign hit[g] = gate && (code == grid_code(2'(g)));
    end

    always_comb begin
        seg = '0;
        for (int g = 0; g < MAX_GRIDS; g++) begin
            if (hit[g]) seg = seg | bank[g];
        end
    end

endmodule

// File: rtl/vfd_scan_dim.sv
module vfd_scan_dim
    import vfd_scan_pkg::*;
#(
    parameter int SEG_W      = 56,
    parameter int DIM_W      = 10,
    parameter int PRESCALE   = 4,
    parameter int SLOT_BITS  = 1024,
    parameter int LEAD_BITS  = 3,
    parameter int SAT_MARGIN = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 master_sel,
    input  logic                 duplex_sel,
    input  logic [DIM_W-1:0]     dim_val,
    input  logic [SEG_W-1:0]     lat1,
    input  logic [SEG_W-1:0]     lat2,
    input  logic [SEG_W-1:0]     lat3,
    input  logic                 dim_in,
    input  logic [1:0]           sync_in,
    output logic [SEG_W-1:0]     seg_out,
    output logic [MAX_GRIDS-1:0] grid_n,
    output logic                 dim_out,
    output logic [1:0]           sync_out
);

    localparam int BIT_W    = $clog2(SLOT_BITS);
    localparam int DUTY_MAX = SLOT_BITS - SAT_MARGIN;
    localparam int WIN_W    = ((BIT_W > DIM_W) ? BIT_W : DIM_W) + 1;

    typedef struct packed {
        logic [SEG_W-1:0]     seg;
        logic [MAX_GRIDS-1:0] grid_n;
        logic                 dim;
        sel_code_t            sync;
    } out_t;

    logic [BIT_W-1:0] bit_pos;
    logic             slot_end;
    logic [1:0]       grid_idx;
    logic [DIM_W-1:0] duty;
    logic [WIN_W-1:0] grid_end;
    logic             grid_on;
    logic             seg_on;
    sel_code_t        sel_code;
    logic             sel_gate;
    logic [SEG_W-1:0] sel_seg;
    out_t             o_d, o_q;

    vfd_bit_timer #(
        .PRESCALE  (PRESCALE),
        .SLOT_BITS (SLOT_BITS)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_pos  (bit_pos),
        .slot_end (slot_end)
    );

    vfd_grid_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .slot_end   (slot_end),
        .duplex_sel (duplex_sel),
        .grid_idx   (grid_idx)
    );

    vfd_duty_reg #(
        .DIM_W    (DIM_W),
        .DUTY_MAX (DUTY_MAX)
    ) u_duty (
        .clk      (clk),
        .rst_n    (rst_n),
        .slot_end (slot_end),
        .dim_val  (dim_val),
        .duty     (duty)
    );

    // Strobe covers [0, D+LEAD); segments cover [LEAD, D+LEAD)
    assign grid_end = WIN_W'(duty) + WIN_W'(LEAD_BITS);
    assign grid_on  = (WIN_W'(bit_pos) < grid_end);
    assign seg_on   = grid_on && (WIN_W'(bit_pos) >= WIN_W'(LEAD_BITS));

    always_comb begin
        if (master_sel) begin
            sel_code = grid_code(grid_idx);
            sel_gate = seg_on;
        end else begin
            sel_code = sync_in;
            sel_gate = dim_in;
        end
    end

    vfd_seg_select #(
        .SEG_W (SEG_W)
    ) u_sel (
        .code  (sel_code),
        .gate  (sel_gate),
        .lat_a (lat1),
        .lat_b (lat2),
        .lat_c (lat3),
        .seg   (sel_seg)
    );

    always_comb begin
        o_d        = o_q;
        o_d.seg    = sel_seg;
        o_d.grid_n = '1;
        o_d.dim    = 1'b0;
        o_d.sync   = SEL_BLANK;
        if (master_sel) begin
            for (int g = 0; g < MAX_GRIDS; g++) begin
                if (grid_on && (grid_idx == 2'(g))) o_d.grid_n[g] = 1'b0;
            end
            o_d.dim  = seg_on;
            o_d.sync = grid_code(grid_idx);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_q.seg    <= '0;
            o_q.grid_n <= '1;
            o_q.dim    <= 1'b0;
            o_q.sync   <= SEL_BLANK;
        end else begin
            o_q <= o_d;
        end
    end

    assign seg_out  = o_q.seg;
    assign grid_n   = o_q.grid_n;
    assign dim_out  = o_q.dim;
    assign sync_out = o_q.sync;

endmodule

// File: rtl/vfd_scan_dim_chk.sv
module vfd_scan_dim_chk #(
    parameter int SEG_W = 56
) (
    input logic             clk,
    input logic             rst_n,
    input logic             master_sel,
    input logic             dim_in,
    input logic [SEG_W-1:0] seg_out,
    input logic [2:0]       grid_n,
    input logic             dim_out,
    input logic [1:0]       sync_out
);

    AST_ONE_GRID: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~grid_n) <= 1); // R11

    AST_PULSE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        dim_out |-> (grid_n != 3'b111)); // R3

    AST_MASTER_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(master_sel) && !dim_out) |-> (seg_out == '0)); // R9

    AST_SLAVE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(master_sel) |-> (grid_n == 3'b111 && !dim_out && sync_out == 2'b00)); // R10

    AST_SLAVE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(master_sel) && !$past(dim_in)) |-> (seg_out == '0)); // R10

    AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (dim_out && $past(dim_out)) |-> $stable(sync_out)); // R8

endmodule

bind vfd_scan_dim vfd_scan_dim_chk #(.SEG_W(SEG_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .master_sel (master_sel),
    .dim_in     (dim_in),
    .seg_out    (seg_out),
    .grid_n     (grid_n),
    .dim_out    (dim_out),
    .sync_out   (sync_out)
);

// File: tb/tb_vfd_scan_dim.sv
`timescale 1ns/1ps
module tb_vfd_scan_dim;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        master_sel, duplex_sel, dim_in;
    logic [9:0]  dim_val;
    logic [55:0] lat1, lat2, lat3;
    logic [1:0]  sync_in;
    logic [55:0] seg_out;
    logic [2:0]  grid_n;
    logic        dim_out;
    logic [1:0]  sync_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    vfd_scan_dim dut (
        .clk(clk), .rst_n(rst_n), .master_sel(master_sel), .duplex_sel(duplex_sel),
        .dim_val(dim_val), .lat1(lat1), .lat2(lat2), .lat3(lat3),
        .dim_in(dim_in), .sync_in(sync_in), .seg_out(seg_out), .grid_n(grid_n),
        .dim_out(dim_out), .sync_out(sync_out)
    );

    task automatic chk_eq(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] code_of(input int g);
        case (g)
            0:       return 2'b01;
            1:       return 2'b10;
            2:       return 2'b11;
            default: return 2'b00;
        endcase
    endfunction

    function automatic logic [55:0] latch_of(input logic [1:0] c);
        case (c)
            2'b01:   return lat1;
            2'b10:   return lat2;
            2'b11:   return lat3;
            default: return 56'd0;
        endcase
    endfunction

    function automatic logic [55:0] rnd56();
        return 56'({$urandom(), $urandom()});
    endfunction

    int m_g, m_lead, m_pw, m_glen;
    bit m_segok, m_syncok, m_excl;

    // Measure one strobe window; optionally change dim_val once it has opened
    task automatic measure(input bit chg, input logic [9:0] nd);
        m_g = -1; m_lead = -1; m_pw = 0; m_glen = 0;
        m_segok = 1; m_syncok = 1; m_excl = 1;
        @(negedge clk);
        while (grid_n == 3'b111) @(negedge clk);
        for (int g = 0; g < 3; g++) if (!grid_n[g]) m_g = g;
        if (chg) dim_val = nd;
        while (!grid_n[m_g]) begin
            m_glen++;
            if (grid_n != ~(3'b001 << m_g)) m_excl = 0;
            if (sync_out != code_of(m_g)) m_syncok = 0;
            if (dim_out) begin
                if (m_lead < 0) m_lead = m_glen - 1;
                m_pw++;
                if (seg_out != latch_of(code_of(m_g))) m_segok = 0;
            end else if (seg_out != 56'd0) begin
                m_segok = 0;
            end
            dim_in  = 1'($urandom());
            sync_in = 2'($urandom());
            @(negedge clk);
        end
        if (m_lead < 0) m_lead = m_glen;
        lat1 = rnd56(); lat2 = rnd56(); lat3 = rnd56();
    endtask

    task automatic slot_check(input string ctx, input int eg, input int d,
                              input bit chg, input logic [9:0] nd);
        measure(chg, nd);
        chk_eq({ctx, " R7 grid order"}, m_g, eg);
        chk_eq({ctx, " R2/R3 strobe width"}, m_glen, (d + 3) * 4);
        chk_eq({ctx, " R3 lead"}, m_lead, 12);
        chk_eq({ctx, " R3 pulse width"}, m_pw, d * 4);
        chk_eq({ctx, " R9 segment data"}, m_segok, 1);
        chk_eq({ctx, " R8 sync code"}, m_syncok, 1);
        chk_eq({ctx, " R11 exclusive strobe"}, m_excl, 1);
    endtask

    initial begin
        int d1, d2;
        logic [1:0] c;
        logic       g;
        void'($urandom(32'd7341));
        d1 = 4 + int'($urandom() % 997);
        d2 = 1 + int'($urandom() % 1015);
        master_sel = 1'b1; duplex_sel = 1'b0; dim_in = 1'b0; sync_in = 2'b00;
        dim_val = 10'(d1);
        lat1 = rnd56(); lat2 = rnd56(); lat3 = rnd56();

        repeat (5) @(negedge clk);
        chk_eq("R1 reset segments", seg_out, 0);
        chk_eq("R1 reset strobes", grid_n, 7);
        chk_eq("R1 reset dim_out", dim_out, 0);
        chk_eq("R1 reset sync_out", sync_out, 0);
        rst_n = 1'b1;

        slot_check("R1 R4 first slot", 0, 0, 1'b0, 10'd0);
        slot_check("triplex", 1, d1, 1'b0, 10'd0);
        slot_check("triplex", 2, d1, 1'b0, 10'd0);
        slot_check("R6 change during slot", 0, d1, 1'b1, 10'd1023);
        slot_check("R5 saturation", 1, 1016, 1'b1, 10'd0);
        slot_check("R4 zero duty", 2, 0, 1'b1, 10'(d2));
        slot_check("R6 new value", 0, d2, 1'b0, 10'd0);

        duplex_sel = 1'b1;
        slot_check("R7 duplex", 1, d2, 1'b0, 10'd0);
        slot_check("R7 duplex", 0, d2, 1'b0, 10'd0);
        slot_check("R7 duplex", 1, d2, 1'b0, 10'd0);
        slot_check("R7 duplex", 0, d2, 1'b0, 10'd0);

        duplex_sel = 1'b0;
        slot_check("R7 back to triplex", 1, d2, 1'b0, 10'd0);
        slot_check("R7 back to triplex", 2, d2, 1'b0, 10'd0);

        // Slave mode: directed codes first, then random
        master_sel = 1'b0;
        for (int i = 0; i < 200; i++) begin
            if (i < 8) begin
                c = 2'(i % 4);
                g = (i < 4);
            end else begin
                c = 2'($urandom());
                g = 1'($urandom());
            end
            if (i % 16 == 0) begin
                lat1 = rnd56(); lat2 = rnd56(); lat3 = rnd56();
            end
            sync_in = c;
            dim_in  = g;
            @(negedge clk);
            chk_eq("R10 slave segments", seg_out, g ? latch_of(c) : 56'd0);
            chk_eq("R10 slave strobes and outputs",
                   {grid_n, dim_out, sync_out}, {3'b111, 1'b0, 2'b00});
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R7 watchdog actual=stalled expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule